// File: doc/BRIEF.md
# Write-Update Home Directory Controller

This block is the home-node controller for a small group of memory lines in a shared-memory system that keeps caches coherent by pushing new values to sharers instead of invalidating them. For every line it holds a line state, a full presence vector with one bit per cache, and the line's data. Caches send it request messages: read miss, write miss, write word, line replacement with or without data, the owner's returned line, and update-word messages that a busy cache handed back. The controller answers with line replies, owner write-back requests, acknowledgements and bounces.

A write to a shared line is sent on to every other sharer as an update-word message. The writer is told how many updates went out, so it can count their acknowledgements. A line held by one owner must first be written back. While the directory waits for that write-back, misses and word writes to the line are bounced to their sender for a later retry.

Requests arrive on a valid/ready input. Messages leave on a valid/ready output, one per cycle. When a request produces several messages, the sharer updates come first, in ascending cache index, and the reply to the requester comes last. No new request is taken while messages from the previous one are still waiting to leave.

Top module: `upd_home_dir`

## Requirements
- R1: After reset every line is Absent, has no presence bits set and holds all-zero data; req_ready is 1 and out_valid is 0.
- R2: A read miss (kind 0) or write miss (kind 1) to an Absent line yields one exclusive reply (kind 0) to the sender. It carries the stored line in out_ldata, leaves memory unchanged, sets the sender's presence bit and moves the line to Exclusive.
- R3: A read miss to a Shared line yields one shared reply (kind 1) to the sender. It carries the line and a count of 0, and it sets the sender's presence bit.
- R4: A write miss to a Shared line writes the word into memory and fans out update-word messages. It then sends a shared reply (kind 1) to the sender whose out_ldata already holds the new word and whose out_count is the number of updates sent. It sets the sender's presence bit.
- R5: A write word (kind 2) to any line that is not Pending writes memory and fans out updates. It ends with a write acknowledge (kind 5) to the sender that echoes the word index and carries the update count. Line state and presence bits do not change.
- R6: A read miss to an Exclusive line sends a write-back request (kind 2) to the owner. A write miss instead writes memory and sends the owner a write-back-with-update (kind 3) carrying the word index and value. In both cases the sender's bit is set and the line becomes Pending.
- R7: While a line is Pending, a read miss, write miss or write word is bounced to its sender as kind 7, 8 or 9 respectively. The bounce echoes the word index and value, and state, presence and memory are not changed.
- R8: An update line (kind 5) to a Pending line writes the full line from req_ldata and moves the line to Shared, or to Absent if no presence bit remains. To any other line it has no effect. It never produces a message.
- R9: A replace (kind 3) or replace with data (kind 4) clears the sender's bit and is answered with a replace acknowledge (kind 6). A Shared or Exclusive line left with no bits becomes Absent. Kind 4 also writes the full line from req_ldata.
- R10: A bounced update (kind 6) is answered with an update-word (kind 4) to its sender. The message carries the word index and memory's current value of that word.
- R11: Update-word messages go to every cache whose bit is set except the writer, one per cycle, in ascending cache index, before the final reply. The final reply's count equals the number sent.
- R12: While out_valid is high and out_ready is low, every output field holds its value. req_ready stays low from the cycle after a request is accepted until its last message has been taken.
- R13: Request kind 7 is accepted and produces no message and no change to any line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 3 | Request kind code |
| req_src | input | clog2(N_CACHE) | Sending cache index |
| req_line | input | clog2(N_LINE) | Line index |
| req_word | input | clog2(WORDS) | Word index within the line |
| req_data | input | DATA_W | Word value |
| req_ldata | input | WORDS*DATA_W | Full line payload, word w at bits w*DATA_W upward |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Receiver takes the message |
| out_kind | output | 4 | Outgoing message kind code |
| out_dst | output | clog2(N_CACHE) | Destination cache index |
| out_line | output | clog2(N_LINE) | Line index |
| out_word | output | clog2(WORDS) | Word index, 0 when unused |
| out_data | output | DATA_W | Word value, 0 when unused |
| out_ldata | output | WORDS*DATA_W | Line payload for replies, 0 otherwise |
| out_count | output | clog2(N_CACHE+1) | Update count for replies to writes, 0 otherwise |

## Verification
A wrong presence bit shows up at the next write to that line as a missing or extra update-word, or as a count that does not match the updates sent. It can also show up as a write-back sent to the wrong owner. A wrong line state shows as the wrong reply kind, or as a bounce that should not happen, on the very next request to that line. A corrupted memory word appears in the next reply or resent update that carries the line. Because the sweep sends many requests to each of a few lines, any such fault reaches the ports within a handful of requests after it is introduced.

// File: rtl/upd_dir_pkg.sv
package upd_dir_pkg;

    typedef enum logic [1:0] {
        LS_ABSENT = 2'd0,
        LS_SHARED = 2'd1,
        LS_EXCL   = 2'd2,
        LS_PEND   = 2'd3
    } line_state_e;

    typedef enum logic [2:0] {
        IK_RD_MISS   = 3'd0,
        IK_WR_MISS   = 3'd1,
        IK_WR_WORD   = 3'd2,
        IK_REPL      = 3'd3,
        IK_REPL_DATA = 3'd4,
        IK_UPD_LINE  = 3'd5,
        IK_UW_BOUNCE = 3'd6,
        IK_RSVD      = 3'd7
    } in_kind_e;

    typedef enum logic [3:0] {
        OK_EXCL_RPLY = 4'd0,
        OK_SHR_RPLY  = 4'd1,
        OK_WB_REQ    = 4'd2,
        OK_WB_UPD    = 4'd3,
        OK_UPD_WORD  = 4'd4,
        OK_WR_ACK    = 4'd5,
        OK_REPL_ACK  = 4'd6,
        OK_BNC_RD    = 4'd7,
        OK_BNC_WM    = 4'd8,
        OK_BNC_WW    = 4'd9
    } out_kind_e;

    // index of the lowest set bit, 0 when none is set
    function automatic int first_one(input logic [31:0] v);
        int r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/upd_dir_linemem.sv
module upd_dir_linemem #(
    parameter int N_LINE = 4,
    parameter int LINE_W = 32,
    localparam int LIDX_W = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LIDX_W-1:0] rd_idx,
    output logic [LINE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [LIDX_W-1:0] wr_idx,
    input  logic [LINE_W-1:0] wr_data
);

    logic [LINE_W-1:0] store_q [N_LINE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_LINE; i++) store_q[i] <= '0;
        end else if (wr_en) begin
            store_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_idx];

endmodule

// File: rtl/upd_dir_entries.sv
module upd_dir_entries
    import upd_dir_pkg::*;
#(
    parameter int N_LINE  = 4,
    parameter int N_CACHE = 4,
    localparam int LIDX_W = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LIDX_W-1:0]  rd_idx,
    output line_state_e        rd_state,
    output logic [N_CACHE-1:0] rd_pres,
    input  logic               wr_en,
    input  logic [LIDX_W-1:0]  wr_idx,
    input  line_state_e        wr_state,
    input  logic [N_CACHE-1:0] wr_pres
);

    line_state_e        state_q [N_LINE];
    logic [N_CACHE-1:0] pres_q  [N_LINE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_LINE; i++) begin
                state_q[i] <= LS_ABSENT;
                pres_q[i]  <= '0;
            end
        end else if (wr_en) begin
            state_q[wr_idx] <= wr_state;
            pres_q[wr_idx]  <= wr_pres;
        end
    end

    assign rd_state = state_q[rd_idx];
    assign rd_pres  = pres_q[rd_idx];

    for (genvar g = 0; g < N_LINE; g++) begin : g_line_chk
        // R9: a line with no copies left is Absent, and an Absent line has no copies
        a_r9_absent_empty: assert property (@(posedge clk) disable iff (rst)
            state_q[g] == LS_ABSENT |-> pres_q[g] == '0);
        // R9: a Shared line always has at least one copy
        a_r9_shared_nonempty: assert property (@(posedge clk) disable iff (rst)
            state_q[g] == LS_SHARED |-> pres_q[g] != '0);
        // R2: an Exclusive line has exactly one owner
        a_r2_excl_single: assert property (@(posedge clk) disable iff (rst)
            state_q[g] == LS_EXCL |-> $countones(pres_q[g]) == 1);
    end

endmodule

// File: rtl/upd_dir_emitter.sv
module upd_dir_emitter
    import upd_dir_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int N_LINE  = 4,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 8,
    localparam int CIDX_W = (N_CACHE > 1) ? $clog2(N_CACHE) : 1,
    localparam int LIDX_W = (N_LINE > 1) ? $clog2(N_LINE) : 1,
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LINE_W = WORDS * DATA_W,
    localparam int CNT_W  = $clog2(N_CACHE + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld,
    input  logic [LIDX_W-1:0]  ld_line,
    input  logic [N_CACHE-1:0] ld_mask,
    input  logic [WIDX_W-1:0]  ld_uword,
    input  logic [DATA_W-1:0]  ld_udata,
    input  out_kind_e          ld_kind,
    input  logic [CIDX_W-1:0]  ld_dst,
    input  logic [WIDX_W-1:0]  ld_word,
    input  logic [DATA_W-1:0]  ld_data,
    input  logic [LINE_W-1:0]  ld_ldata,
    input  logic [CNT_W-1:0]   ld_count,
    output logic               idle,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [3:0]         out_kind,
    output logic [CIDX_W-1:0]  out_dst,
    output logic [LIDX_W-1:0]  out_line,
    output logic [WIDX_W-1:0]  out_word,
    output logic [DATA_W-1:0]  out_data,
    output logic [LINE_W-1:0]  out_ldata,
    output logic [CNT_W-1:0]   out_count
);

    logic               busy_q;
    logic [N_CACHE-1:0] mask_q;
    logic [LIDX_W-1:0]  line_q;
    logic [WIDX_W-1:0]  uword_q;
    logic [DATA_W-1:0]  udata_q;
    out_kind_e          kind_q;
    logic [CIDX_W-1:0]  dst_q;
    logic [WIDX_W-1:0]  word_q;
    logic [DATA_W-1:0]  data_q;
    logic [LINE_W-1:0]  ldata_q;
    logic [CNT_W-1:0]   count_q;
    logic [CNT_W-1:0]   sent_q;

    logic beat_done;
    assign beat_done = busy_q && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            mask_q  <= '0;
            line_q  <= '0;
            uword_q <= '0;
            udata_q <= '0;
            kind_q  <= OK_REPL_ACK;
            dst_q   <= '0;
            word_q  <= '0;
            data_q  <= '0;
            ldata_q <= '0;
            count_q <= '0;
            sent_q  <= '0;
        end else if (ld) begin
            busy_q  <= 1'b1;
            mask_q  <= ld_mask;
            line_q  <= ld_line;
            uword_q <= ld_uword;
            udata_q <= ld_udata;
            kind_q  <= ld_kind;
            dst_q   <= ld_dst;
            word_q  <= ld_word;
            data_q  <= ld_data;
            ldata_q <= ld_ldata;
            count_q <= ld_count;
            sent_q  <= '0;
        end else if (beat_done) begin
            if (mask_q != '0) begin
                mask_q <= mask_q & (mask_q - 1'b1);
                sent_q <= sent_q + 1'b1;
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    assign idle      = !busy_q;
    assign out_valid = busy_q;
    assign out_line  = line_q;

    always_comb begin
        if (mask_q != '0) begin
            out_kind  = OK_UPD_WORD;
            out_dst   = CIDX_W'(first_one(32'(mask_q)));
            out_word  = uword_q;
            out_data  = udata_q;
            out_ldata = '0;
            out_count = '0;
        end else begin
            out_kind  = kind_q;
            out_dst   = dst_q;
            out_word  = word_q;
            out_data  = data_q;
            out_ldata = ldata_q;
            out_count = count_q;
        end
    end

    // R12: a message waiting on the receiver does not change
    a_r12_hold_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_dst)
            && $stable(out_line) && $stable(out_word) && $stable(out_data)
            && $stable(out_ldata) && $stable(out_count));

    // R11: successive updates of one fan-out go to rising cache indices
    a_r11_ascending: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && ((mask_q & (mask_q - 1'b1)) != '0)
            |=> out_kind == OK_UPD_WORD && out_dst > $past(out_dst));

    // R11: the count in the final reply equals the updates that went out
    a_r11_count_matches: assert property (@(posedge clk) disable iff (rst)
        out_valid && mask_q == '0 && (out_kind == OK_SHR_RPLY || out_kind == OK_WR_ACK)
            |-> out_count == sent_q);

endmodule

// File: rtl/upd_home_dir.sv
module upd_home_dir
    import upd_dir_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int N_LINE  = 4,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 8,
    localparam int CIDX_W = (N_CACHE > 1) ? $clog2(N_CACHE) : 1,
    localparam int LIDX_W = (N_LINE > 1) ? $clog2(N_LINE) : 1,
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LINE_W = WORDS * DATA_W,
    localparam int CNT_W  = $clog2(N_CACHE + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [CIDX_W-1:0] req_src,
    input  logic [LIDX_W-1:0] req_line,
    input  logic [WIDX_W-1:0] req_word,
    input  logic [DATA_W-1:0] req_data,
    input  logic [LINE_W-1:0] req_ldata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [3:0]        out_kind,
    output logic [CIDX_W-1:0] out_dst,
    output logic [LIDX_W-1:0] out_line,
    output logic [WIDX_W-1:0] out_word,
    output logic [DATA_W-1:0] out_data,
    output logic [LINE_W-1:0] out_ldata,
    output logic [CNT_W-1:0]  out_count
);

    typedef struct packed {
        out_kind_e         kind;
        logic [CIDX_W-1:0] dst;
        logic [WIDX_W-1:0] word;
        logic [DATA_W-1:0] data;
        logic [LINE_W-1:0] ldata;
        logic [CNT_W-1:0]  count;
    } msg_t;

    logic               accept;
    logic               emit_idle;
    line_state_e        cur_state;
    logic [N_CACHE-1:0] cur_pres;
    logic [LINE_W-1:0]  cur_line;
    logic [N_CACHE-1:0] src_bit;
    logic [N_CACHE-1:0] others;
    logic [N_CACHE-1:0] dropped;
    logic [LINE_W-1:0]  merged;
    logic [DATA_W-1:0]  cur_word;
    logic [CIDX_W-1:0]  owner;

    line_state_e        nxt_state;
    logic [N_CACHE-1:0] nxt_pres;
    logic               ent_we;
    logic               mem_we;
    logic [LINE_W-1:0]  mem_wdata;
    logic               emit_ld;
    logic [N_CACHE-1:0] fan_mask;
    msg_t               fin;

    assign req_ready = emit_idle;
    assign accept    = req_valid && emit_idle;

    upd_dir_entries #(.N_LINE(N_LINE), .N_CACHE(N_CACHE)) u_entries (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (req_line),
        .rd_state (cur_state),
        .rd_pres  (cur_pres),
        .wr_en    (ent_we && accept),
        .wr_idx   (req_line),
        .wr_state (nxt_state),
        .wr_pres  (nxt_pres)
    );

    upd_dir_linemem #(.N_LINE(N_LINE), .LINE_W(LINE_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (req_line),
        .rd_data (cur_line),
        .wr_en   (mem_we && accept),
        .wr_idx  (req_line),
        .wr_data (mem_wdata)
    );

    // operands shared by all request kinds
    always_comb begin
        src_bit          = '0;
        src_bit[req_src] = 1'b1;
        others           = cur_pres & ~src_bit;
        dropped          = cur_pres & ~src_bit;
        merged           = cur_line;
        merged[int'(req_word) * DATA_W +: DATA_W] = req_data;
        cur_word         = cur_line[int'(req_word) * DATA_W +: DATA_W];
        owner            = CIDX_W'(first_one(32'(cur_pres)));
    end

    // per-line protocol decisions
    always_comb begin
        nxt_state = cur_state;
        nxt_pres  = cur_pres;
        ent_we    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = merged;
        emit_ld   = 1'b0;
        fan_mask  = '0;
        fin       = '{kind: OK_REPL_ACK, dst: req_src, word: '0, data: '0,
                      ldata: '0, count: '0};
        case (in_kind_e'(req_kind))
            IK_RD_MISS: begin
                emit_ld = 1'b1;
                case (cur_state)
                    LS_ABSENT: begin
                        ent_we    = 1'b1;
                        nxt_pres  = cur_pres | src_bit;
                        nxt_state = LS_EXCL;
                        fin.kind  = OK_EXCL_RPLY;
                        fin.ldata = cur_line;
                    end
                    LS_SHARED: begin
                        ent_we    = 1'b1;
                        nxt_pres  = cur_pres | src_bit;
                        fin.kind  = OK_SHR_RPLY;
                        fin.ldata = cur_line;
                    end
                    LS_EXCL: begin
                        ent_we    = 1'b1;
                        nxt_pres  = cur_pres | src_bit;
                        nxt_state = LS_PEND;
                        fin.kind  = OK_WB_REQ;
                        fin.dst   = owner;
                    end
                    default: begin
                        fin.kind = OK_BNC_RD;
                        fin.word = req_word;
                        fin.data = req_data;
                    end
                endcase
            end
            IK_WR_MISS: begin
                emit_ld = 1'b1;
                case (cur_state)
                    LS_ABSENT: begin
                        ent_we    = 1'b1;
                        nxt_pres  = cur_pres | src_bit;
                        nxt_state = LS_EXCL;
                        fin.kind  = OK_EXCL_RPLY;
                        fin.ldata = cur_line;
                    end
                    LS_SHARED: begin
                        ent_we    = 1'b1;
                        mem_we    = 1'b1;
                        nxt_pres  = cur_pres | src_bit;
                        fan_mask  = others;
                        fin.kind  = OK_SHR_RPLY;
                        fin.ldata = merged;
                        fin.count = CNT_W'($countones(others));
                    end
                    LS_EXCL: begin
                        ent_we    = 1'b1;
                        mem_we    = 1'b1;
                        nxt_pres  = cur_pres | src_bit;
                        nxt_state = LS_PEND;
                        fin.kind  = OK_WB_UPD;
                        fin.dst   = owner;
                        fin.word  = req_word;
                        fin.data  = req_data;
                    end
                    default: begin
                        fin.kind = OK_BNC_WM;
                        fin.word = req_word;
                        fin.data = req_data;
                    end
                endcase
            end
            IK_WR_WORD: begin
                emit_ld = 1'b1;
                if (cur_state == LS_PEND) begin
                    fin.kind = OK_BNC_WW;
                    fin.word = req_word;
                    fin.data = req_data;
                end else begin
                    mem_we    = 1'b1;
                    fan_mask  = others;
                    fin.kind  = OK_WR_ACK;
                    fin.word  = req_word;
                    fin.count = CNT_W'($countones(others));
                end
            end
            IK_REPL, IK_REPL_DATA: begin
                emit_ld  = 1'b1;
                ent_we   = 1'b1;
                nxt_pres = dropped;
                if (dropped == '0 && (cur_state == LS_SHARED || cur_state == LS_EXCL))
                    nxt_state = LS_ABSENT;
                if (in_kind_e'(req_kind) == IK_REPL_DATA) begin
                    mem_we    = 1'b1;
                    mem_wdata = req_ldata;
                end
                fin.kind = OK_REPL_ACK;
            end
            IK_UPD_LINE: begin
                if (cur_state == LS_PEND) begin
                    ent_we    = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = req_ldata;
                    nxt_state = (cur_pres == '0) ? LS_ABSENT : LS_SHARED;
                end
            end
            IK_UW_BOUNCE: begin
                emit_ld  = 1'b1;
                fin.kind = OK_UPD_WORD;
                fin.word = req_word;
                fin.data = cur_word;
            end
            default: ;
        endcase
    end

    upd_dir_emitter #(
        .N_CACHE(N_CACHE), .N_LINE(N_LINE), .WORDS(WORDS), .DATA_W(DATA_W)
    ) u_emit (
        .clk       (clk),
        .rst       (rst),
        .ld        (emit_ld && accept),
        .ld_line   (req_line),
        .ld_mask   (fan_mask),
        .ld_uword  (req_word),
        .ld_udata  (req_data),
        .ld_kind   (fin.kind),
        .ld_dst    (fin.dst),
        .ld_word   (fin.word),
        .ld_data   (fin.data),
        .ld_ldata  (fin.ldata),
        .ld_count  (fin.count),
        .idle      (emit_idle),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_kind  (out_kind),
        .out_dst   (out_dst),
        .out_line  (out_line),
        .out_word  (out_word),
        .out_data  (out_data),
        .out_ldata (out_ldata),
        .out_count (out_count)
    );

    // R12: an outgoing batch only starts right after a request was taken
    a_r12_out_after_accept: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(req_valid && req_ready));

endmodule

// File: tb/upd_home_dir_test.sv
`timescale 1ns/1ps
module upd_home_dir_test;

    localparam int K_RD = 0, K_WM = 1, K_WW = 2, K_RL = 3, K_RLD = 4,
                   K_UL = 5, K_UWB = 6, K_RSV = 7;
    localparam int O_EXCL = 0, O_SHR = 1, O_WBR = 2, O_WBU = 3, O_UPD = 4,
                   O_ACK = 5, O_RACK = 6, O_BRD = 7, O_BWM = 8, O_BWW = 9;
    localparam int S_ABS = 0, S_SHR = 1, S_EXC = 2, S_PND = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [1:0]  req_src = '0;
    logic [1:0]  req_line = '0;
    logic [1:0]  req_word = '0;
    logic [7:0]  req_data = '0;
    logic [31:0] req_ldata = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [3:0]  out_kind;
    logic [1:0]  out_dst;
    logic [1:0]  out_line;
    logic [1:0]  out_word;
    logic [7:0]  out_data;
    logic [31:0] out_ldata;
    logic [2:0]  out_count;

    always #2.5 clk = ~clk;

    upd_home_dir uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_line(req_line), .req_word(req_word),
        .req_data(req_data), .req_ldata(req_ldata),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_dst(out_dst), .out_line(out_line), .out_word(out_word),
        .out_data(out_data), .out_ldata(out_ldata), .out_count(out_count)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference state built from the requirements
    int          st   [4];
    logic [3:0]  pres [4];
    logic [7:0]  mem  [4][4];

    int          e_n;
    int          e_kind [8];
    int          e_dst  [8];
    int          e_word [8];
    logic [7:0]  e_data [8];
    logic [31:0] e_ld   [8];
    int          e_cnt  [8];
    string       e_tag  [8];
    string       q_tag;
    int          cur_line;

    function automatic logic [31:0] linev(input int l);
        return {mem[l][3], mem[l][2], mem[l][1], mem[l][0]};
    endfunction

    function automatic int lowest(input logic [3:0] v);
        int r;
        r = 0;
        for (int i = 3; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    task automatic push(input int k, input int d, input int w, input logic [7:0] x,
                        input logic [31:0] ld, input int c, input string tag);
        e_kind[e_n] = k; e_dst[e_n] = d; e_word[e_n] = w; e_data[e_n] = x;
        e_ld[e_n] = ld; e_cnt[e_n] = c; e_tag[e_n] = tag;
        e_n++;
    endtask

    task automatic fan(input int l, input int s, input int w, input logic [7:0] x,
                       output int cnt);
        cnt = 0;
        for (int c = 0; c < 4; c++) begin
            if (pres[l][c] && c != s) begin
                push(O_UPD, c, w, x, 32'h0, 0, "R11");
                cnt++;
            end
        end
    endtask

    task automatic model(input int k, input int s, input int l, input int w,
                         input logic [7:0] d, input logic [31:0] ld);
        int own;
        int cnt;
        e_n = 0;
        q_tag = "R13";
        cur_line = l;
        own = lowest(pres[l]);
        case (k)
            K_RD: case (st[l])
                S_ABS: begin push(O_EXCL, s, 0, 8'h0, linev(l), 0, "R2");
                             pres[l][s] = 1'b1; st[l] = S_EXC; end
                S_SHR: begin push(O_SHR, s, 0, 8'h0, linev(l), 0, "R3");
                             pres[l][s] = 1'b1; end
                S_EXC: begin push(O_WBR, own, 0, 8'h0, 32'h0, 0, "R6");
                             pres[l][s] = 1'b1; st[l] = S_PND; end
                default: push(O_BRD, s, w, d, 32'h0, 0, "R7");
            endcase
            K_WM: case (st[l])
                S_ABS: begin push(O_EXCL, s, 0, 8'h0, linev(l), 0, "R2");
                             pres[l][s] = 1'b1; st[l] = S_EXC; end
                S_SHR: begin mem[l][w] = d; fan(l, s, w, d, cnt);
                             push(O_SHR, s, 0, 8'h0, linev(l), cnt, "R4");
                             pres[l][s] = 1'b1; end
                S_EXC: begin mem[l][w] = d; push(O_WBU, own, w, d, 32'h0, 0, "R6");
                             pres[l][s] = 1'b1; st[l] = S_PND; end
                default: push(O_BWM, s, w, d, 32'h0, 0, "R7");
            endcase
            K_WW: begin
                if (st[l] == S_PND) push(O_BWW, s, w, d, 32'h0, 0, "R7");
                else begin
                    mem[l][w] = d; fan(l, s, w, d, cnt);
                    push(O_ACK, s, w, 8'h0, 32'h0, cnt, "R5");
                end
            end
            K_RL, K_RLD: begin
                if (k == K_RLD)
                    for (int i = 0; i < 4; i++) mem[l][i] = ld[i*8 +: 8];
                pres[l][s] = 1'b0;
                if (pres[l] == 4'b0 && (st[l] == S_SHR || st[l] == S_EXC)) st[l] = S_ABS;
                push(O_RACK, s, 0, 8'h0, 32'h0, 0, "R9");
            end
            K_UL: begin
                q_tag = "R8";
                if (st[l] == S_PND) begin
                    for (int i = 0; i < 4; i++) mem[l][i] = ld[i*8 +: 8];
                    st[l] = (pres[l] == 4'b0) ? S_ABS : S_SHR;
                end
            end
            K_UWB: push(O_UPD, s, w, mem[l][w], 32'h0, 0, "R10");
            default: ;
        endcase
    endtask

    task automatic check_beat(input int i, input string why);
        n_checks++;
        if (!(out_valid === 1'b1 && int'(out_kind) == e_kind[i] && int'(out_dst) == e_dst[i]
              && int'(out_line) == cur_line && int'(out_word) == e_word[i]
              && out_data === e_data[i] && out_ldata === e_ld[i]
              && int'(out_count) == e_cnt[i])) begin
            n_fail++;
            $display("FAIL %s beat %0d: got v=%0b k=%0d dst=%0d ln=%0d w=%0d d=%h ld=%h c=%0d exp v=1 k=%0d dst=%0d ln=%0d w=%0d d=%h ld=%h c=%0d",
                why, i, out_valid, out_kind, out_dst, out_line, out_word, out_data,
                out_ldata, out_count, e_kind[i], e_dst[i], cur_line, e_word[i],
                e_data[i], e_ld[i], e_cnt[i]);
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string why);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b exp %b", why, act, exp);
        end
    endtask

    // entered and left just after a falling edge
    task automatic apply(input int k, input int s, input int l, input int w,
                         input logic [7:0] d, input logic [31:0] ld, input int stall);
        req_kind = 3'(k); req_src = 2'(s); req_line = 2'(l); req_word = 2'(w);
        req_data = d; req_ldata = ld; req_valid = 1'b1;
        check_bit(req_ready, 1'b1, "R12 ready when idle");
        model(k, s, l, w, d, ld);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < e_n; i++) begin
            for (int t = 0; t < stall; t++) begin
                out_ready = 1'b0;
                check_beat(i, {e_tag[i], " R12 held"});
                check_bit(req_ready, 1'b0, "R12 busy");
                @(negedge clk);
            end
            out_ready = 1'b1;
            check_beat(i, e_tag[i]);
            @(negedge clk);
        end
        check_bit(out_valid, 1'b0, (e_n == 0) ? q_tag : "R11 batch end");
        check_bit(req_ready, 1'b1, "R12 ready after batch");
    endtask

    function automatic logic [31:0] xs(input logic [31:0] v);
        logic [31:0] r;
        r = v ^ (v << 13);
        r = r ^ (r >> 17);
        r = r ^ (r << 5);
        return r;
    endfunction

    initial begin
        logic [31:0] rnd;
        int k;
        for (int l = 0; l < 4; l++) begin
            st[l] = S_ABS; pres[l] = 4'b0;
            for (int w = 0; w < 4; w++) mem[l][w] = 8'h0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state at the ports
        check_bit(req_ready, 1'b1, "R1 ready");
        check_bit(out_valid, 1'b0, "R1 out idle");

        // directed walk on line 0
        apply(K_RD, 1, 0, 0, 8'h00, 32'h0, 0);          // R2 zero line, exclusive
        apply(K_RD, 2, 0, 0, 8'h00, 32'h0, 1);          // R6 write-back to owner 1
        apply(K_WW, 1, 0, 3, 8'h77, 32'h0, 0);          // R7 bounced
        apply(K_RD, 3, 0, 1, 8'h12, 32'h0, 0);          // R7
        apply(K_WM, 3, 0, 2, 8'h34, 32'h0, 2);          // R7
        apply(K_UL, 1, 0, 0, 8'h00, 32'h44332211, 0);   // R8 -> Shared
        apply(K_RD, 3, 0, 0, 8'h00, 32'h0, 0);          // R3
        apply(K_WM, 0, 0, 2, 8'hAA, 32'h0, 1);          // R4 three updates
        apply(K_WW, 2, 0, 1, 8'h55, 32'h0, 2);          // R5 R11
        apply(K_UWB, 3, 0, 1, 8'h00, 32'h0, 0);         // R10 current word
        apply(K_RSV, 2, 0, 0, 8'hFF, 32'hFFFFFFFF, 0);  // R13
        apply(K_RL, 0, 0, 0, 8'h00, 32'h0, 0);          // R9
        apply(K_RL, 1, 0, 0, 8'h00, 32'h0, 0);
        apply(K_RL, 2, 0, 0, 8'h00, 32'h0, 0);
        apply(K_RLD, 3, 0, 0, 8'h00, 32'hDEADBEEF, 0);  // R9 last copy, data
        apply(K_UL, 0, 0, 0, 8'h00, 32'h01020304, 0);   // R8 ignored
        apply(K_RD, 0, 0, 0, 8'h00, 32'h0, 0);          // R2 shows memory kept
        apply(K_WM, 2, 1, 1, 8'h9C, 32'h0, 0);          // R2 memory untouched
        apply(K_WM, 0, 1, 3, 8'h3D, 32'h0, 1);          // R6 write-back with update
        apply(K_UL, 2, 1, 0, 8'h00, 32'h00003D9C, 0);   // R8
        apply(K_RD, 1, 1, 0, 8'h00, 32'h0, 0);          // R3

        // sweep: mixed requests over all lines, caches and words
        rnd = 32'h1234_5679;
        for (int n = 0; n < 1500; n++) begin
            rnd = xs(rnd);
            case (rnd[3:0])
                4'd0, 4'd1, 4'd2, 4'd3: k = K_RD;
                4'd4, 4'd5, 4'd6:       k = K_WM;
                4'd7, 4'd8:             k = K_WW;
                4'd9, 4'd10:            k = K_RL;
                4'd11:                  k = K_RLD;
                4'd12, 4'd13:           k = K_UL;
                4'd14:                  k = K_UWB;
                default:                k = K_RSV;
            endcase
            apply(k, int'(rnd[5:4]), int'(rnd[7:6]), int'(rnd[9:8]), rnd[17:10],
                  xs(rnd ^ 32'hA5A5_0F0F), int'(rnd[19:18]) % 3);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule